// File: doc/BRIEF.md
# Speculative Load Conflict Checker

This block lets a pipeline move a load above earlier stores and find out afterwards whether that move was safe. When the hoisted load executes, its byte address is written into a small table slot chosen by a tag. Every store that follows is compared in one cycle against all occupied slots. A slot whose address falls in the same 8-byte block as the store is marked as conflicted.

At the point in program order where the load used to be, a check request names the same tag. One cycle later the block reports whether the speculation held: success if the slot is occupied and no store touched its block, failure otherwise. The check then releases the slot. The memory and any replay after a failed check lie outside this block.

Top module: `spec_load_guard`

## Requirements
- R1: During reset and after it, every slot is empty and `res_valid` and `res_ok` are low, so a check on any tag straight after reset fails.
- R2: A check on a slot that was filled and never hit by a store yields `res_valid` high with `res_ok` = 1 in the cycle after `chk_valid`. `res_valid` is high exactly in the cycles that follow a cycle with `chk_valid` high.
- R3: A store marks a slot as conflicted when the slot is occupied and address bits [31:3] of the store equal those of the slot. Bits [2:0] play no part. A later check on that slot reports `res_ok` = 0.
- R4: A store whose bits [31:3] differ from those of a slot has no effect on that slot, and its check still reports success.
- R5: A check on a tag that was never loaded reports `res_ok` = 0.
- R6: A check releases its slot, so a second check on the same tag without a new load reports `res_ok` = 0.
- R7: A load to an occupied tag replaces the stored address and clears the conflict mark.
- R8: A store and a check that land on the same slot in the same cycle are ordered store first, so the check reports `res_ok` = 0.
- R9: A load and a check on the same tag in the same cycle are ordered check first. The check judges the old slot contents, and the slot then holds the new load, clean and occupied.
- R10: A load and a store in the same cycle are ordered store first, so the new slot is not marked even when the addresses share a block.
- R11: One store marks every occupied slot whose block it matches, in the same cycle.
- R12: `res_ok` is low in every cycle in which `res_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_valid | input | 1 | A hoisted load executes this cycle |
| ld_tag | input | 3 | Slot to fill |
| ld_addr | input | 32 | Byte address of the load |
| st_valid | input | 1 | A store executes this cycle |
| st_addr | input | 32 | Byte address of the store |
| chk_valid | input | 1 | A check on a slot is requested |
| chk_tag | input | 3 | Slot to check and release |
| res_valid | output | 1 | Check result is present |
| res_ok | output | 1 | 1 = speculation held, 0 = it failed |

## Verification
In a single cycle the block can receive a store and a check on the same slot, or a load and a check on the same tag. The bench drives both requests on the same falling edge. One case pairs a check with a store that matches the slot's block, and another pairs it with a store that does not. A third case puts a fresh load and a check on the same tag, once over a clean slot and once over a conflicted slot. A reference table kept in the bench applies the store before the check, and the check before the load. The scoreboard then compares the result for that cycle, and a further check on the same tag confirms what the slot holds afterwards.

// File: rtl/slg_pkg.sv
package slg_pkg;

  // Update applied to one slot in a cycle, in priority order.
  typedef enum logic [1:0] {
    UPD_HOLD = 2'd0,
    UPD_FILL = 2'd1,
    UPD_FREE = 2'd2,
    UPD_MARK = 2'd3
  } slg_upd_e;

  typedef struct packed {
    logic occupied;
    logic tainted;
  } slg_flags_t;

  // Pick the update: a load wins over a release, and a release wins over a mark.
  function automatic slg_upd_e slg_pick_upd(input logic fill, input logic free,
                                            input logic mark);
    if (fill)      return UPD_FILL;
    else if (free) return UPD_FREE;
    else if (mark) return UPD_MARK;
    else           return UPD_HOLD;
  endfunction

  // Next slot flags for an update.
  function automatic slg_flags_t slg_next_flags(input slg_upd_e upd,
                                                input slg_flags_t cur);
    slg_flags_t nxt;
    nxt = cur;
    case (upd)
      UPD_FILL: begin nxt.occupied = 1'b1; nxt.tainted = 1'b0; end
      UPD_FREE: begin nxt.occupied = 1'b0; nxt.tainted = 1'b0; end
      UPD_MARK: nxt.tainted = 1'b1;
      default:  nxt = cur;
    endcase
    return nxt;
  endfunction

  // Verdict of a check: the slot must be occupied, unmarked and not hit now.
  function automatic logic slg_verdict(input slg_flags_t cur, input logic hit_now);
    return cur.occupied & ~cur.tainted & ~hit_now;
  endfunction

endpackage

// File: rtl/slg_match.sv
module slg_match #(
  parameter int ADDR_W   = 32,
  parameter int GRAN_LSB = 3
) (
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [ADDR_W-1:0] addr_b,
  output logic              same_block
);

  localparam int BLK_W = ADDR_W - GRAN_LSB;

  function automatic logic block_eq(input logic [ADDR_W-1:0] a,
                                    input logic [ADDR_W-1:0] b);
    logic [BLK_W-1:0] ba;
    logic [BLK_W-1:0] bb;
    ba = a[ADDR_W-1:GRAN_LSB];
    bb = b[ADDR_W-1:GRAN_LSB];
    return ba == bb;
  endfunction

  assign same_block = block_eq(addr_a, addr_b);

endmodule

// File: rtl/slg_slot.sv
module slg_slot
  import slg_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int GRAN_LSB = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill,
  input  logic              free,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  output logic              occupied,
  output logic              tainted,
  output logic              st_hit
);

  slg_flags_t        flags_q;
  slg_flags_t        flags_d;
  logic [ADDR_W-1:0] addr_q;
  logic              blk_eq;
  slg_upd_e          upd;

  slg_match #(.ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB)) u_match (
    .addr_a    (st_addr),
    .addr_b    (addr_q),
    .same_block(blk_eq)
  );

  assign st_hit  = st_valid & flags_q.occupied & blk_eq;
  assign upd     = slg_pick_upd(fill, free, st_hit);
  assign flags_d = slg_next_flags(upd, flags_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      addr_q  <= '0;
    end else begin
      flags_q <= flags_d;
      if (upd == UPD_FILL) addr_q <= fill_addr;
    end
  end

  assign occupied = flags_q.occupied;
  assign tainted  = flags_q.tainted;

endmodule

// File: rtl/slg_verdict.sv
module slg_verdict
  import slg_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int TAG_W       = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   chk_valid,
  input  logic [TAG_W-1:0]       chk_tag,
  input  logic [NUM_ENTRIES-1:0] occ_vec,
  input  logic [NUM_ENTRIES-1:0] taint_vec,
  input  logic [NUM_ENTRIES-1:0] hit_vec,
  output logic                   res_valid,
  output logic                   res_ok
);

  slg_flags_t sel_flags;
  logic       sel_hit;
  logic       ok_d;

  assign sel_flags.occupied = occ_vec[chk_tag];
  assign sel_flags.tainted  = taint_vec[chk_tag];
  assign sel_hit            = hit_vec[chk_tag];
  assign ok_d               = chk_valid & slg_verdict(sel_flags, sel_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_ok    <= 1'b0;
    end else begin
      res_valid <= chk_valid;
      res_ok    <= ok_d;
    end
  end

endmodule

// File: rtl/spec_load_guard.sv
module spec_load_guard #(
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_W      = 32,
  parameter int GRAN_LSB    = 3,
  localparam int TAG_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              chk_valid,
  input  logic [TAG_W-1:0]  chk_tag,
  output logic              res_valid,
  output logic              res_ok
);

  // Named internal events, also watched by the bound checker.
  logic [NUM_ENTRIES-1:0] ld_sel;
  logic [NUM_ENTRIES-1:0] chk_sel;
  logic [NUM_ENTRIES-1:0] st_hit;
  logic [NUM_ENTRIES-1:0] ent_valid;
  logic [NUM_ENTRIES-1:0] ent_conflict;

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_slot
    assign ld_sel[i]  = ld_valid  & (ld_tag  == TAG_W'(i));
    assign chk_sel[i] = chk_valid & (chk_tag == TAG_W'(i));

    slg_slot #(.ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .fill     (ld_sel[i]),
      .free     (chk_sel[i]),
      .fill_addr(ld_addr),
      .st_valid (st_valid),
      .st_addr  (st_addr),
      .occupied (ent_valid[i]),
      .tainted  (ent_conflict[i]),
      .st_hit   (st_hit[i])
    );
  end

  slg_verdict #(.NUM_ENTRIES(NUM_ENTRIES), .TAG_W(TAG_W)) u_verdict (
    .clk      (clk),
    .rst_n    (rst_n),
    .chk_valid(chk_valid),
    .chk_tag  (chk_tag),
    .occ_vec  (ent_valid),
    .taint_vec(ent_conflict),
    .hit_vec  (st_hit),
    .res_valid(res_valid),
    .res_ok   (res_ok)
  );

endmodule

// File: rtl/slg_checker.sv
module slg_checker #(
  parameter int NUM_ENTRIES = 8,
  parameter int TAG_W       = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   chk_valid,
  input logic [TAG_W-1:0]       chk_tag,
  input logic [NUM_ENTRIES-1:0] ld_sel,
  input logic [NUM_ENTRIES-1:0] chk_sel,
  input logic [NUM_ENTRIES-1:0] st_hit,
  input logic [NUM_ENTRIES-1:0] ent_valid,
  input logic [NUM_ENTRIES-1:0] ent_conflict,
  input logic                   res_valid,
  input logic                   res_ok
);

  logic [NUM_ENTRIES-1:0] mark_only;
  logic [NUM_ENTRIES-1:0] free_only;
  assign mark_only = st_hit & ~ld_sel & ~chk_sel;
  assign free_only = chk_sel & ~ld_sel;

  assert_reset_empty_R1: assert property (@(posedge clk)
    !rst_n |=> (ent_valid == '0 && !res_valid && !res_ok));

  assert_result_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> res_valid);

  assert_no_stray_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |=> !res_valid);

  assert_store_marks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|mark_only) |=> ((ent_conflict & $past(mark_only)) == $past(mark_only)));

  assert_check_frees_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|free_only) |=> ((ent_valid & $past(free_only)) == '0));

  assert_fill_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|ld_sel) |=> (((ent_valid & $past(ld_sel)) == $past(ld_sel)) &&
                   ((ent_conflict & $past(ld_sel)) == '0)));

  assert_store_before_check_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && st_hit[chk_tag]) |=> (res_valid && !res_ok));

  assert_ok_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> !res_ok);

  assert_mark_needs_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_conflict & ~ent_valid) == '0);

  assert_one_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ld_sel));

endmodule

bind spec_load_guard slg_checker #(.NUM_ENTRIES(NUM_ENTRIES), .TAG_W(TAG_W)) u_slg_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .chk_valid   (chk_valid),
  .chk_tag     (chk_tag),
  .ld_sel      (ld_sel),
  .chk_sel     (chk_sel),
  .st_hit      (st_hit),
  .ent_valid   (ent_valid),
  .ent_conflict(ent_conflict),
  .res_valid   (res_valid),
  .res_ok      (res_ok)
);

// File: tb/sim_spec_load_guard.sv
module sim_spec_load_guard;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0;
  logic [2:0]  ld_tag = '0;
  logic [31:0] ld_addr = '0;
  logic        st_valid = 1'b0;
  logic [31:0] st_addr = '0;
  logic        chk_valid = 1'b0;
  logic [2:0]  chk_tag = '0;
  logic        res_valid;
  logic        res_ok;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference table.
  bit          m_occ [8];
  bit          m_mark[8];
  logic [31:0] m_addr[8];

  bit    exp_q[$];
  string req_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spec_load_guard u0 (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_tag(ld_tag), .ld_addr(ld_addr),
    .st_valid(st_valid), .st_addr(st_addr),
    .chk_valid(chk_valid), .chk_tag(chk_tag),
    .res_valid(res_valid), .res_ok(res_ok)
  );

  function automatic bit same_blk(input logic [31:0] a, input logic [31:0] b);
    return (a >> 3) == (b >> 3);
  endfunction

  // One cycle of stimulus; ordering inside a cycle is store, then check, then load.
  task automatic step(input bit l, input logic [2:0] lt, input logic [31:0] la,
                      input bit s, input logic [31:0] sa,
                      input bit c, input logic [2:0] ct, input string req);
    @(negedge clk);
    ld_valid = l; ld_tag = lt; ld_addr = la;
    st_valid = s; st_addr = sa;
    chk_valid = c; chk_tag = ct;
    if (s)
      for (int i = 0; i < 8; i++)
        if (m_occ[i] && same_blk(sa, m_addr[i])) m_mark[i] = 1'b1;
    if (c) begin
      exp_q.push_back(m_occ[ct] && !m_mark[ct]);
      req_q.push_back(req);
      m_occ[ct] = 1'b0; m_mark[ct] = 1'b0;
    end
    if (l) begin
      m_occ[lt] = 1'b1; m_mark[lt] = 1'b0; m_addr[lt] = la;
    end
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, "");
  endtask

  task automatic load(input logic [2:0] t, input logic [31:0] a);
    step(1, t, a, 0, 0, 0, 0, "");
  endtask

  task automatic store(input logic [31:0] a);
    step(0, 0, 0, 1, a, 0, 0, "");
  endtask

  task automatic check(input logic [2:0] t, input string req);
    step(0, 0, 0, 0, 0, 1, t, req);
  endtask

  // Monitor: compares each result against the queued expectation.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (!res_valid && res_ok) begin
        errors++;
        $display("FAIL R12: res_ok=%0b expected 0 while res_valid low", res_ok);
      end
      if (res_valid) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R2: res_valid=1 expected 0 (no check pending)");
        end else begin
          bit e;
          string r;
          e = exp_q.pop_front();
          r = req_q.pop_front();
          if (res_ok !== e) begin
            errors++;
            $display("FAIL %s: res_ok=%0b expected %0b", r, res_ok, e);
          end
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_occ[i] = 0; m_mark[i] = 0; m_addr[i] = '0; end
    repeat (3) @(negedge clk);
    checks++;
    if (res_valid !== 1'b0 || res_ok !== 1'b0) begin
      errors++;
      $display("FAIL R1: res_valid=%0b res_ok=%0b expected 0 0", res_valid, res_ok);
    end
    rst_n = 1'b1;

    // R1 / R5: every tag empty after reset
    for (int t = 0; t < 8; t++) check(3'(t), "R1");

    // R2: clean loads succeed, back-to-back checks
    load(0, 32'h0000_1000);
    load(1, 32'h0000_2000);
    idle();
    check(0, "R2");
    check(1, "R2");

    // R3: store in the same 8-byte block, other byte offset
    load(2, 32'h0000_3000);
    store(32'h0000_3004);
    check(2, "R3");

    // R4: store to the adjacent block
    load(3, 32'h0000_4000);
    store(32'h0000_4008);
    check(3, "R4");

    // R6 / R5: released slot and never-loaded slot
    check(3, "R6");
    check(5, "R5");

    // R7: reload clears the mark and takes the new address
    load(4, 32'h0000_5000);
    store(32'h0000_5000);
    load(4, 32'h0000_6000);
    store(32'h0000_5000);
    check(4, "R7");

    // R8: store and check on the same slot in one cycle
    load(5, 32'h0000_7000);
    step(0, 0, 0, 1, 32'h0000_7003, 1, 5, "R8");
    load(6, 32'h0000_8000);
    step(0, 0, 0, 1, 32'h0000_9000, 1, 6, "R8");

    // R9: load and check on one tag in one cycle
    load(7, 32'h0000_A000);
    step(1, 7, 32'h0000_B000, 0, 0, 1, 7, "R9");
    check(7, "R9");
    load(0, 32'h0000_C000);
    store(32'h0000_C000);
    step(1, 0, 32'h0000_D000, 0, 0, 1, 0, "R9");
    check(0, "R9");

    // R10: load and matching store in one cycle
    step(1, 1, 32'h0000_E000, 1, 32'h0000_E000, 0, 0, "");
    check(1, "R10");

    // R11: one store marks several slots
    load(2, 32'h0000_F000);
    load(3, 32'h0000_F004);
    load(4, 32'h0000_F010);
    store(32'h0000_F006);
    check(2, "R11");
    check(3, "R11");
    check(4, "R11");

    repeat (4) idle();
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2: %0d results missing, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule